// File: doc/BRIEF.md
# Bit Test and Modify Unit

This unit carries out a single bit-test operation on a 16-bit or 32-bit operand. The operation either only reads the selected bit, or reads it and then complements, sets or clears it. The operand is either a register value presented on the port or a word in memory. The bit that was selected, taken before any change, is returned as the carry flag.

For a memory operand, the bit offset is signed and may reach beyond the addressed word. The unit splits the offset into a bit index inside the word and a signed word displacement. It adds that displacement to the base byte address. It then reads the word over a request/acknowledge handshake. Unless the operation is test-only, it writes the modified word back to the same address.

A request for a 64-bit operand is refused: the unit signals an error and makes no memory access. Each operation ends with a one-cycle `done` pulse. The flag and result outputs are meaningful only during that pulse.

Top module: `bit_modify_unit`

## Requirements
- R1: `op_mode` selects the operation: 0 tests only, 1 inverts the selected bit, 2 forces it to 1, 3 forces it to 0. All other bits of the operand keep their value.
- R2: The bit index is `bit_offset[4:0]` for a 32-bit operand (`op_size`=1) and `bit_offset[3:0]` for a 16-bit operand (`op_size`=0).
- R3: For a 32-bit memory operand, the access address is `base_addr` plus 4 times the signed value of `bit_offset` with its low 5 bits cleared, divided by 32.
- R4: For a 16-bit memory operand, only `bit_offset[15:0]` is used. The access address is `base_addr` plus 2 times the signed value of that field with its low 4 bits cleared, divided by 16. A 16-bit access uses `mem_rdata[15:0]`, drives `mem_wdata[31:16]` to zero and holds `mem_wide` low.
- R5: A test-only operation on memory performs exactly one read and no write.
- R6: Modes 1 to 3 on memory perform one read and then one write of the modified word. The write goes to the address of the read, and `mem_addr` stays unchanged between the two accesses.
- R7: A register operand (`dest_is_mem`=0) makes no memory access and applies no displacement. `done` rises in the cycle after the accepting clock edge, and `reg_result` carries the modified value.
- R8: `op_size` of 2 or 3 (a 64-bit request) ends with `size_error`=1, `carry`=0 and no memory access.
- R9: During `done`, `carry` equals the selected bit of the original operand, in every mode.
- R10: `done` lasts exactly one cycle. `busy` is high from the accepting edge until the operation returns to idle, and `start` is ignored while `busy` is high.
- R11: Once raised, `mem_req` stays high with a stable `mem_addr` until `mem_ack` is seen.
- R12: After reset, `busy`, `done`, `mem_req` and `size_error` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation; accepted only when idle |
| op_mode | input | 2 | 0 test, 1 invert, 2 set, 3 clear |
| op_size | input | 2 | 0 16-bit, 1 32-bit, 2/3 64-bit (refused) |
| dest_is_mem | input | 1 | 1 selects a memory operand, 0 a register operand |
| base_addr | input | ADDR_W | Byte address of the memory operand |
| bit_offset | input | WORD_W | Bit offset; signed for memory operands |
| reg_value | input | WORD_W | Register operand value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| carry | output | 1 | Original value of the selected bit |
| size_error | output | 1 | Unsupported operand size |
| reg_result | output | WORD_W | Modified register value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_wide | output | 1 | Request is 32-bit (else 16-bit) |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | WORD_W | Write data |
| mem_ack | input | 1 | One-cycle acknowledge of the current request |
| mem_rdata | input | WORD_W | Read data, valid with `mem_ack` |

## Verification
The checks assume that `mem_ack` is a single-cycle pulse that arrives only while `mem_req` is high. They also assume that `mem_req` is always answered. The bench memory model therefore acknowledges only pending requests, always drops the acknowledge after one cycle, and inserts a random wait of zero to two cycles. Operation inputs are assumed to matter only on the accepting edge. To show this, the bench deliberately raises `start` with different arguments while an operation is busy. It also fills the unused upper half of 16-bit read data with random values, which must not leak into the result.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

    typedef enum logic [1:0] {
        OP_TEST  = 2'd0,
        OP_FLIP  = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } bmu_op_e;

    typedef enum logic [1:0] {
        SZ_HALF  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_RSVD  = 2'd3
    } bmu_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } bmu_state_e;

endpackage

// File: rtl/bmu_addr_gen.sv
module bmu_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [WORD_W-1:0] offset,
    input  logic              wide,
    input  logic              is_mem,
    output logic [ADDR_W-1:0] addr
);
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int HALF_W = WORD_W / 2;
    localparam int WSH    = $clog2(WORD_W / 8);
    localparam int HSH    = WSH - 1;

    logic signed [WORD_W-1:0] words_w;
    logic signed [HALF_W-1:0] words_h;
    logic signed [ADDR_W-1:0] disp_w;
    logic signed [ADDR_W-1:0] disp_h;
    logic signed [ADDR_W-1:0] byte_disp;

    // arithmetic shift equals exact signed division once low bits are dropped
    assign words_w   = $signed(offset) >>> IDX_W;
    assign words_h   = $signed(offset[HALF_W-1:0]) >>> (IDX_W - 1);
    assign disp_w    = ADDR_W'(words_w);
    assign disp_h    = ADDR_W'(words_h);
    assign byte_disp = wide ? (disp_w <<< WSH) : (disp_h <<< HSH);
    assign addr      = is_mem ? base + $unsigned(byte_disp) : base;

endmodule

// File: rtl/bmu_alu.sv
module bmu_alu
    import bmu_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0]         word_in,
    input  logic [$clog2(WORD_W)-1:0] idx,
    input  bmu_op_e                   op,
    output logic [WORD_W-1:0]         word_out,
    output logic                      bit_val
);
    logic [WORD_W-1:0] sel_mask;

    assign sel_mask = {{(WORD_W-1){1'b0}}, 1'b1} << idx;
    assign bit_val  = |(word_in & sel_mask);

    always_comb begin
        unique case (op)
            OP_FLIP:  word_out = word_in ^ sel_mask;
            OP_SET:   word_out = word_in | sel_mask;
            OP_CLEAR: word_out = word_in & ~sel_mask;
            default:  word_out = word_in;
        endcase
    end

endmodule

// File: rtl/bit_modify_unit.sv
module bit_modify_unit
    import bmu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_mode,
    input  logic [1:0]        op_size,
    input  logic              dest_is_mem,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [WORD_W-1:0] bit_offset,
    input  logic [WORD_W-1:0] reg_value,
    output logic              busy,
    output logic              done,
    output logic              carry,
    output logic              size_error,
    output logic [WORD_W-1:0] reg_result,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wide,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int HALF_W = WORD_W / 2;

    typedef struct packed {
        bmu_state_e        st;
        bmu_op_e           op;
        logic              wide;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
        logic [WORD_W-1:0] result;
        logic              carry;
        logic              err;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic              req_wide;
    logic              req_bad;
    logic [IDX_W-1:0]  req_idx;
    logic [ADDR_W-1:0] req_addr;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] alu_in;
    logic [IDX_W-1:0]  alu_idx;
    bmu_op_e           alu_op;
    logic [WORD_W-1:0] alu_out;
    logic              alu_bit;

    assign req_wide = (bmu_size_e'(op_size) == SZ_WORD);
    assign req_bad  = op_size[1];
    assign req_idx  = req_wide ? bit_offset[IDX_W-1:0]
                               : {1'b0, bit_offset[IDX_W-2:0]};

    bmu_addr_gen #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_addr (
        .base   (base_addr),
        .offset (bit_offset),
        .wide   (req_wide),
        .is_mem (dest_is_mem),
        .addr   (req_addr)
    );

    assign rd_word = ctx_q.wide ? mem_rdata
                                : {{HALF_W{1'b0}}, mem_rdata[HALF_W-1:0]};

    // the idle path works on the register operand, the read path on memory data
    assign alu_in  = (ctx_q.st == ST_IDLE) ? reg_value : rd_word;
    assign alu_idx = (ctx_q.st == ST_IDLE) ? req_idx : ctx_q.idx;
    assign alu_op  = (ctx_q.st == ST_IDLE) ? bmu_op_e'(op_mode) : ctx_q.op;

    bmu_alu #(
        .WORD_W (WORD_W)
    ) u_alu (
        .word_in  (alu_in),
        .idx      (alu_idx),
        .op       (alu_op),
        .word_out (alu_out),
        .bit_val  (alu_bit)
    );

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctx_d.op     = bmu_op_e'(op_mode);
                    ctx_d.wide   = req_wide;
                    ctx_d.idx    = req_idx;
                    ctx_d.addr   = req_addr;
                    ctx_d.wdata  = '0;
                    ctx_d.result = '0;
                    ctx_d.carry  = 1'b0;
                    ctx_d.err    = 1'b0;
                    if (req_bad) begin
                        ctx_d.err = 1'b1;
                        ctx_d.st  = ST_DONE;
                    end else if (!dest_is_mem) begin
                        ctx_d.carry  = alu_bit;
                        ctx_d.result = alu_out;
                        ctx_d.st     = ST_DONE;
                    end else begin
                        ctx_d.st = ST_READ;
                    end
                end
            end
            ST_READ: begin
                if (mem_ack) begin
                    ctx_d.carry = alu_bit;
                    ctx_d.wdata = ctx_q.wide ? alu_out
                                             : {{HALF_W{1'b0}}, alu_out[HALF_W-1:0]};
                    ctx_d.st    = (ctx_q.op == OP_TEST) ? ST_DONE : ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    ctx_d.st = ST_DONE;
                end
            end
            default: begin
                ctx_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign busy       = (ctx_q.st != ST_IDLE);
    assign done       = (ctx_q.st == ST_DONE);
    assign carry      = ctx_q.carry;
    assign size_error = ctx_q.err;
    assign reg_result = ctx_q.result;
    assign mem_req    = (ctx_q.st == ST_READ) || (ctx_q.st == ST_WRITE);
    assign mem_we     = (ctx_q.st == ST_WRITE);
    assign mem_wide   = ctx_q.wide;
    assign mem_addr   = ctx_q.addr;
    assign mem_wdata  = ctx_q.wdata;

endmodule

// File: rtl/bmu_checker.sv
module bmu_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        op_mode,
    input logic [1:0]        op_size,
    input logic              dest_is_mem,
    input logic              busy,
    input logic              done,
    input logic              size_error,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr
);
    logic accept;
    logic test_pend, reg_pend, err_pend;

    assign accept = start && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            test_pend <= 1'b0;
            reg_pend  <= 1'b0;
            err_pend  <= 1'b0;
        end else if (accept) begin
            test_pend <= (op_mode == 2'd0) && !op_size[1];
            reg_pend  <= !dest_is_mem;
            err_pend  <= op_size[1];
        end else if (done) begin
            test_pend <= 1'b0;
            reg_pend  <= 1'b0;
            err_pend  <= 1'b0;
        end
    end

    p_test_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        test_pend |-> !(mem_req && mem_we));

    p_wb_same_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> mem_req && $stable(mem_addr));

    p_reg_no_mem_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_pend |-> !mem_req);

    p_wide_no_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_pend |-> !mem_req);

    p_wide_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pend && done) |-> size_error);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr));

endmodule

bind bit_modify_unit bmu_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .op_mode     (op_mode),
    .op_size     (op_size),
    .dest_is_mem (dest_is_mem),
    .busy        (busy),
    .done        (done),
    .size_error  (size_error),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_ack     (mem_ack),
    .mem_addr    (mem_addr)
);

// File: tb/sim_bit_modify_unit.sv
module sim_bit_modify_unit;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op_mode = '0;
    logic [1:0]  op_size = '0;
    logic        dest_is_mem = 1'b0;
    logic [31:0] base_addr = '0;
    logic [31:0] bit_offset = '0;
    logic [31:0] reg_value = '0;
    logic        busy, done, carry, size_error, mem_req, mem_we, mem_wide;
    logic [31:0] reg_result, mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int errors = 0;
    int checks = 0;

    logic [7:0]  mem [256];
    int          rd_cnt, wr_cnt, lat;
    logic [31:0] last_rd, last_wr;

    always #(CLK_P/2) clk = ~clk;

    bit_modify_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_mode(op_mode),
        .op_size(op_size), .dest_is_mem(dest_is_mem), .base_addr(base_addr),
        .bit_offset(bit_offset), .reg_value(reg_value), .busy(busy),
        .done(done), .carry(carry), .size_error(size_error),
        .reg_result(reg_result), .mem_req(mem_req), .mem_we(mem_we),
        .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_rd(input logic [31:0] a, input bit wide);
        logic [31:0] w;
        for (int i = 0; i < 4; i++) w[8*i +: 8] = mem[8'(a + 32'(i))];
        if (!wide) w[31:16] = '0;
        return w;
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] base, input logic [31:0] off, input bit wide);
        int q;
        shortint h;
        if (wide) begin
            q = int'(off & 32'hFFFF_FFE0) / 32;
            return base + 32'(q * 4);
        end
        h = shortint'(off[15:0] & 16'hFFF0);
        q = int'(h) / 16;
        return base + 32'(q * 2);
    endfunction

    function automatic logic [31:0] exp_new(input logic [31:0] w, input int idx, input logic [1:0] m);
        logic [31:0] r = w;
        case (m)
            2'd1: r[idx] = ~w[idx];
            2'd2: r[idx] = 1'b1;
            2'd3: r[idx] = 1'b0;
            default: r = w;
        endcase
        return r;
    endfunction

    // memory responder: single-cycle ack after 0..2 wait cycles
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            lat = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (lat == 0) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    wr_cnt++;
                    last_wr = mem_addr;
                    for (int i = 0; i < (mem_wide ? 4 : 2); i++)
                        mem[8'(mem_addr + 32'(i))] = mem_wdata[8*i +: 8];
                end else begin
                    rd_cnt++;
                    last_rd = mem_addr;
                    mem_rdata = model_rd(mem_addr, mem_wide);
                    if (!mem_wide) mem_rdata[31:16] = 16'($urandom);
                end
                lat = $urandom % 3;
            end else begin
                lat--;
            end
        end
    end

    task automatic run_op(input logic [1:0] m, input logic [1:0] sz, input bit is_mem,
                          input logic [31:0] base, input logic [31:0] off,
                          input logic [31:0] rv, input bit poke);
        bit          wide = (sz == 2'd1);
        bit          bad = sz[1];
        int          idx = wide ? int'(off[4:0]) : int'(off[3:0]);
        logic [31:0] ea = is_mem ? exp_addr(base, off, wide) : base;
        logic [31:0] orig, expw, memw;
        int          cyc;
        orig = is_mem ? model_rd(ea, wide) : rv;
        expw = exp_new(orig, idx, m);
        rd_cnt = 0;
        wr_cnt = 0;
        @(negedge clk);
        start = 1'b1; op_mode = m; op_size = sz; dest_is_mem = is_mem;
        base_addr = base; bit_offset = off; reg_value = rv;
        @(negedge clk);
        chk(busy == 1'b1, "R10 busy after accept", 32'(busy), 32'd1);
        if (poke) begin
            op_mode = ~m; base_addr = base + 32'h40; bit_offset = off ^ 32'h7;
        end else begin
            start = 1'b0;
        end
        cyc = 1;
        while (!done && cyc < 50) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        start = 1'b0;
        chk(done == 1'b1, "R10 done seen", 32'(done), 32'd1);
        if (bad) begin
            chk(size_error == 1'b1, "R8 size_error", 32'(size_error), 32'd1);
            chk(carry == 1'b0, "R8 carry cleared", 32'(carry), 32'd0);
            chk(rd_cnt + wr_cnt == 0, "R8 no memory access", 32'(rd_cnt + wr_cnt), 32'd0);
        end else begin
            chk(size_error == 1'b0, "R8 no error on supported size", 32'(size_error), 32'd0);
            chk(carry == orig[idx], "R9 carry is original bit", 32'(carry), 32'(orig[idx]));
            if (!is_mem) begin
                chk(cyc == 1, "R7 register latency", 32'(cyc), 32'd1);
                chk(rd_cnt + wr_cnt == 0, "R7 register no memory", 32'(rd_cnt + wr_cnt), 32'd0);
                chk(reg_result == expw, "R1 R2 register result", reg_result, expw);
            end else begin
                memw = model_rd(ea, wide);
                chk(rd_cnt == 1, "R5 R6 one read", 32'(rd_cnt), 32'd1);
                chk(last_rd == ea, wide ? "R3 read address" : "R4 read address", last_rd, ea);
                chk(memw == expw, "R1 R2 memory word", memw, expw);
                if (m == 2'd0) begin
                    chk(wr_cnt == 0, "R5 no write in test mode", 32'(wr_cnt), 32'd0);
                end else begin
                    chk(wr_cnt == 1, "R6 one write", 32'(wr_cnt), 32'd1);
                    chk(last_wr == ea, "R6 write address", last_wr, ea);
                end
            end
        end
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", 32'(done), 32'd0);
        chk(busy == 1'b0, "R10 idle after done", 32'(busy), 32'd0);
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R12 reset idle", {30'd0, busy, done}, 32'd0);
        chk(mem_req == 1'b0 && size_error == 1'b0, "R12 reset bus", {30'd0, mem_req, size_error}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        run_op(2'd0, 2'd1, 1'b1, 32'h80, 32'hFFFF_FFFF, '0, 1'b0); // R3 -1 -> previous word, bit 31
        run_op(2'd1, 2'd1, 1'b1, 32'h80, 32'h0000_0045, '0, 1'b0); // R3 +2 words, bit 5
        run_op(2'd2, 2'd0, 1'b1, 32'h90, 32'h0000_FFF0, '0, 1'b0); // R4 -1 half, bit 0
        run_op(2'd3, 2'd0, 1'b1, 32'h90, 32'h1234_0025, '0, 1'b0); // R4 upper half ignored
        run_op(2'd2, 2'd1, 1'b0, 32'h80, 32'h0000_0025, 32'h0, 1'b0); // R2 R7 bit 5
        run_op(2'd3, 2'd0, 1'b0, 32'h80, 32'hFFFF_FF13, 32'hFFFF_FFFF, 1'b0); // R2 bit 3 of 16
        run_op(2'd1, 2'd2, 1'b1, 32'h80, 32'h5, '0, 1'b0); // R8
        run_op(2'd0, 2'd3, 1'b0, 32'h80, 32'h5, 32'hFF, 1'b0); // R8
        run_op(2'd1, 2'd1, 1'b1, 32'hA0, 32'h0000_0003, '0, 1'b1); // R10 start ignored while busy
        run_op(2'd0, 2'd0, 1'b1, 32'hA2, 32'h0000_000F, '0, 1'b1); // R10

        // constrained random
        for (int n = 0; n < 400; n++) begin
            logic [1:0]  m  = 2'($urandom);
            logic [1:0]  sz = ($urandom % 10 == 0) ? 2'd2 + 2'($urandom % 2) : 2'($urandom % 2);
            bit          im = ($urandom % 4) != 0;
            logic [31:0] b  = 32'h40 + 32'($urandom % 128);
            logic [31:0] o  = 32'(int'($urandom % 512) - 256);
            b = (sz == 2'd1) ? {b[31:2], 2'b00} : {b[31:1], 1'b0};
            if (sz == 2'd0 && ($urandom % 2)) o[31:16] = 16'($urandom);
            run_op(m, sz, im, b, o, $urandom, ($urandom % 8) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule